// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer with Per-Entry Direction Counters

This block sits beside the fetch address register and answers, within the same cycle, one question for each fetch address: is this address a known branch, and if it is, should fetch jump? A small direct-mapped table is indexed by the word-address bits of the fetch PC. Each entry holds the complete address of the branch that owns it, the target that branch last went to, a valid flag and a 2-bit saturating direction counter. An entry is used only when it is valid and its stored address equals the fetch PC, so two branches that share an index can never lend each other a target. On a hit whose counter leans taken, the stored target becomes the next fetch address. In every other case fetch moves on sequentially.

When a branch resolves in the back end, an update port trains the table. A taken branch that does not own its slot claims it: it writes its address and target and starts at weakly taken. A taken branch that already owns its slot refreshes the target and strengthens its counter. A not-taken branch that owns its slot weakens its counter. A not-taken branch without an entry leaves the table alone. The direction counter is a four-state machine with these states: STRONG_NT (00), WEAK_NT (01), WEAK_T (10) and STRONG_T (11). It has these transitions: INSTALL (any state to WEAK_T), TAKEN (one step toward STRONG_T, which holds at STRONG_T) and NOT_TAKEN (one step toward STRONG_NT, which holds at STRONG_NT).

Top module: `btb_dm_predictor`

## Requirements
- R1: After reset every entry is invalid, so every lookup reports pred_hit=0, pred_state=00 and next_pc = fetch_pc+4.
- R2: The entry index is fetch_pc[log2(DEPTH)+1:2]. A hit needs the entry to be valid and its stored address to equal all ADDR_W bits of fetch_pc.
- R3: On a miss, pred_hit=0, pred_taken=0, pred_state=00 and next_pc = fetch_pc+4.
- R4: On a hit whose state is 10 or 11, pred_taken=1 and next_pc equals the stored target.
- R5: On a hit whose state is 00 or 01, pred_hit=1, pred_taken=0, pred_state shows the stored state and next_pc = fetch_pc+4.
- R6: A resolved taken branch whose address is not held valid at its index writes its address and target into that entry, sets the entry valid and sets its state to 10. Any previous occupant is replaced.
- R7: A resolved taken branch that hits replaces the stored target with the new target and moves the state one step up, holding at 11.
- R8: A resolved not-taken branch that hits moves the state one step down, holding at 00. The stored address and target do not change.
- R9: A resolved not-taken branch that misses changes nothing. The entry already held at that index keeps its address, target and state.
- R10: A fetch PC that shares an index with a valid entry but differs in any other address bit misses.
- R11: Lookup is combinational. An update becomes visible only after the next rising clock edge, so a lookup made in the same cycle as an update still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; clears every valid flag |
| fetch_pc | input | ADDR_W | Current fetch address |
| next_pc | output | ADDR_W | Predicted next fetch address |
| pred_hit | output | 1 | The fetch PC matched a valid entry |
| pred_taken | output | 1 | A hit whose counter leans taken |
| pred_state | output | 2 | Counter of the hit entry; 00 on a miss |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| upd_target | input | ADDR_W | Resolved target address |

## Verification
The bench builds the block with DEPTH=8 and ADDR_W=32. With only eight slots, fetch addresses drawn from a pool of 32 words put four distinct branches on each index. Aliasing, replacement of an occupant, and not-taken misses that land on an occupied slot therefore happen constantly in the random phase, not once in a while. The shallow table also lets a directed sequence drive one entry through every counter state and both saturation points within a few dozen cycles.

// File: rtl/btb_pkg.sv
package btb_pkg;

    // Direction counter states; the MSB is the taken/not-taken lean.
    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_state_e;

    // Training event applied to one entry's counter.
    typedef enum logic [1:0] {
        EV_NONE,
        EV_INSTALL,
        EV_TAKEN,
        EV_NOT_TAKEN
    } ctr_event_e;

endpackage

// File: rtl/btb_ctr_fsm.sv
module btb_ctr_fsm
    import btb_pkg::*;
(
    input  ctr_state_e cur_state,
    input  ctr_event_e event_in,
    output ctr_state_e nxt_state
);

    always_comb begin
        nxt_state = cur_state;
        unique case (event_in)
            EV_NONE:    nxt_state = cur_state;
            EV_INSTALL: nxt_state = CTR_WEAK_T;
            EV_TAKEN: begin
                unique case (cur_state)
                    CTR_STRONG_NT: nxt_state = CTR_WEAK_NT;
                    CTR_WEAK_NT:   nxt_state = CTR_WEAK_T;
                    CTR_WEAK_T:    nxt_state = CTR_STRONG_T;
                    CTR_STRONG_T:  nxt_state = CTR_STRONG_T;
                endcase
            end
            EV_NOT_TAKEN: begin
                unique case (cur_state)
                    CTR_STRONG_NT: nxt_state = CTR_STRONG_NT;
                    CTR_WEAK_NT:   nxt_state = CTR_STRONG_NT;
                    CTR_WEAK_T:    nxt_state = CTR_WEAK_NT;
                    CTR_STRONG_T:  nxt_state = CTR_WEAK_T;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/btb_entry_store.sv
module btb_entry_store
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic                     rd_valid,
    output logic [ADDR_W-1:0]        rd_tag,
    output logic [ADDR_W-1:0]        rd_tgt,
    output ctr_state_e               rd_ctr,
    input  logic                     upd_valid,
    input  logic [ADDR_W-1:0]        upd_pc,
    input  logic                     upd_taken,
    input  logic [ADDR_W-1:0]        upd_target
);

    localparam int IDX_W = $clog2(DEPTH);

    logic [DEPTH-1:0]  valid_w;
    logic [ADDR_W-1:0] tag_w [DEPTH];
    logic [ADDR_W-1:0] tgt_w [DEPTH];
    ctr_state_e        ctr_w [DEPTH];

    logic [IDX_W-1:0]  upd_idx;
    logic              upd_hit;
    ctr_event_e        upd_event;
    ctr_state_e        ctr_nxt;
    logic              wr_en;
    logic              load_fields;

    assign upd_idx = upd_pc[IDX_W+1:2];
    assign upd_hit = valid_w[upd_idx] && (tag_w[upd_idx] == upd_pc);

    // Classify the resolved branch into a counter event.
    always_comb begin
        upd_event = EV_NONE;
        if (upd_valid) begin
            if (upd_taken) upd_event = upd_hit ? EV_TAKEN : EV_INSTALL;
            else           upd_event = upd_hit ? EV_NOT_TAKEN : EV_NONE;
        end
    end

    assign wr_en       = (upd_event != EV_NONE);
    assign load_fields = (upd_event == EV_INSTALL) || (upd_event == EV_TAKEN);

    btb_ctr_fsm u_ctr (
        .cur_state (ctr_w[upd_idx]),
        .event_in  (upd_event),
        .nxt_state (ctr_nxt)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : gen_entry
        logic              valid_q;
        logic [ADDR_W-1:0] tag_q;
        logic [ADDR_W-1:0] tgt_q;
        ctr_state_e        ctr_q;
        logic              sel;

        assign sel = wr_en && (upd_idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q <= 1'b0;
                ctr_q   <= CTR_STRONG_NT;
            end else if (sel) begin
                if (load_fields) valid_q <= 1'b1;
                ctr_q <= ctr_nxt;
            end
        end

        always_ff @(posedge clk) begin
            if (sel && load_fields) begin
                tag_q <= upd_pc;
                tgt_q <= upd_target;
            end
        end

        assign valid_w[g] = valid_q;
        assign tag_w[g]   = tag_q;
        assign tgt_w[g]   = tgt_q;
        assign ctr_w[g]   = ctr_q;
    end

    assign rd_valid = valid_w[rd_idx];
    assign rd_tag   = tag_w[rd_idx];
    assign rd_tgt   = tgt_w[rd_idx];
    assign rd_ctr   = ctr_w[rd_idx];

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (valid_w == '0)); // R1

    AST_INSTALL_WEAK_T: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && !upd_hit) |=>
            (valid_w[$past(upd_idx)] && ctr_w[$past(upd_idx)] == CTR_WEAK_T
             && tag_w[$past(upd_idx)] == $past(upd_pc))); // R6

    AST_TAKEN_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && upd_hit) |=>
            (tgt_w[$past(upd_idx)] == $past(upd_target)
             && ctr_w[$past(upd_idx)] >= $past(ctr_w[upd_idx]))); // R7

    AST_NT_KEEPS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && upd_hit) |=>
            (tgt_w[$past(upd_idx)] == $past(tgt_w[upd_idx])
             && ctr_w[$past(upd_idx)] <= $past(ctr_w[upd_idx]))); // R8

    AST_NT_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken) |=> $stable(valid_w)); // R9

endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_tag,
    input  logic [ADDR_W-1:0] rd_tgt,
    input  ctr_state_e        rd_ctr,
    output logic [ADDR_W-1:0] next_pc,
    output logic              hit,
    output logic              taken,
    output logic [1:0]        state
);

    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);

    always_comb begin
        hit   = rd_valid && (rd_tag == fetch_pc);
        taken = hit && rd_ctr[1];
        state = hit ? rd_ctr : CTR_STRONG_NT;
        next_pc = taken ? rd_tgt : (fetch_pc + WORD_STEP);
    end

endmodule

// File: rtl/btb_dm_predictor.sv
module btb_dm_predictor
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic [ADDR_W-1:0] next_pc,
    output logic              pred_hit,
    output logic              pred_taken,
    output logic [1:0]        pred_state,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target
);

    localparam int IDX_W = $clog2(DEPTH);

    logic [IDX_W-1:0]  rd_idx;
    logic              rd_valid;
    logic [ADDR_W-1:0] rd_tag;
    logic [ADDR_W-1:0] rd_tgt;
    ctr_state_e        rd_ctr;

    assign rd_idx = fetch_pc[IDX_W+1:2];

    btb_entry_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (rd_idx),
        .rd_valid   (rd_valid),
        .rd_tag     (rd_tag),
        .rd_tgt     (rd_tgt),
        .rd_ctr     (rd_ctr),
        .upd_valid  (upd_valid),
        .upd_pc     (upd_pc),
        .upd_taken  (upd_taken),
        .upd_target (upd_target)
    );

    btb_lookup #(.ADDR_W(ADDR_W)) u_lookup (
        .fetch_pc (fetch_pc),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_tgt   (rd_tgt),
        .rd_ctr   (rd_ctr),
        .next_pc  (next_pc),
        .hit      (pred_hit),
        .taken    (pred_taken),
        .state    (pred_state)
    );

    AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken |-> (pred_hit && pred_state[1])); // R4

    AST_MISS_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_hit |-> (next_pc == fetch_pc + ADDR_W'(4) && pred_state == 2'b00)); // R3

endmodule

// File: tb/btb_dm_predictor_test.sv
`timescale 1ns/1ps
module btb_dm_predictor_test;

    localparam int AW = 32;
    localparam int D  = 8;
    localparam int IW = $clog2(D);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [AW-1:0] fetch_pc = '0;
    logic [AW-1:0] upd_pc = '0;
    logic [AW-1:0] upd_target = '0;
    logic          upd_valid = 1'b0;
    logic          upd_taken = 1'b0;
    logic [AW-1:0] next_pc;
    logic          pred_hit;
    logic          pred_taken;
    logic [1:0]    pred_state;

    btb_dm_predictor #(.ADDR_W(AW), .DEPTH(D)) uut (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .next_pc(next_pc),
        .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_state(pred_state),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Behavioural reference table
    bit            mv   [D];
    logic [AW-1:0] mtag [D];
    logic [AW-1:0] mtgt [D];
    int            mst  [D];

    function automatic int ix(logic [AW-1:0] a);
        return int'(a[IW+1:2]);
    endfunction

    function automatic void chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endfunction

    task automatic model_compare();
        int i = ix(fetch_pc);
        bit h = mv[i] && (mtag[i] == fetch_pc);
        int s = h ? mst[i] : 0;
        bit t = h && (s >= 2);
        logic [AW-1:0] n = t ? mtgt[i] : fetch_pc + 4;
        string tag = !h ? "R3" : (t ? "R4" : "R5");
        chk(next_pc === n, tag, 64'(next_pc), 64'(n));
        chk({pred_hit, pred_taken, pred_state} === {h, t, 2'(s)}, tag,
            64'({pred_hit, pred_taken, pred_state}), 64'({h, t, 2'(s)}));
    endtask

    task automatic put(logic [AW-1:0] pc, bit uv, logic [AW-1:0] upc, bit ut,
                       logic [AW-1:0] utg);
        @(negedge clk);
        fetch_pc = pc; upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_target = utg;
        #1;
        model_compare();
    endtask

    task automatic tick();
        @(posedge clk);
        if (upd_valid) begin
            int i = ix(upd_pc);
            bit h = mv[i] && (mtag[i] == upd_pc);
            if (upd_taken) begin
                if (h) begin
                    mtgt[i] = upd_target;
                    if (mst[i] < 3) mst[i]++;
                end else begin
                    mv[i] = 1; mtag[i] = upd_pc; mtgt[i] = upd_target; mst[i] = 2;
                end
            end else if (h && mst[i] > 0) begin
                mst[i]--;
            end
        end
    endtask

    task automatic expect_out(bit h, int s, logic [AW-1:0] n, string tag);
        chk(pred_hit === h && pred_state === 2'(s), tag,
            64'({pred_hit, pred_state}), 64'({h, 2'(s)}));
        chk(next_pc === n, tag, 64'(next_pc), 64'(n));
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    localparam logic [AW-1:0] A = 32'h0000_1000;
    localparam logic [AW-1:0] B = A + 32'(D * 4);   // same index as A

    initial begin
        for (int i = 0; i < D; i++) begin
            mv[i] = 0; mtag[i] = '0; mtgt[i] = '0; mst[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        put(32'h100, 0, '0, 0, '0); expect_out(0, 0, 32'h104, "R1"); tick();
        put(A, 0, '0, 0, '0);       expect_out(0, 0, A + 4, "R1");   tick();

        // R11: install in same cycle as lookup; old contents still seen
        put(A, 1, A, 1, 32'h2000);  expect_out(0, 0, A + 4, "R11");  tick();
        put(A, 0, '0, 0, '0);       expect_out(1, 2, 32'h2000, "R6"); tick();
        put(A, 1, A, 0, '0);        expect_out(1, 2, 32'h2000, "R11"); tick();
        put(A, 0, '0, 0, '0);       expect_out(1, 1, A + 4, "R8");   tick();
        put(A, 1, A, 0, '0); tick();
        put(A, 1, A, 0, '0); tick();
        put(A, 0, '0, 0, '0);       expect_out(0 == 0, 0, A + 4, "R8"); tick();

        // R7: taken hit refreshes target and counts up to saturation
        put(A, 1, A, 1, 32'h3000); tick();
        put(A, 0, '0, 0, '0);       expect_out(1, 1, A + 4, "R7");   tick();
        put(A, 1, A, 1, 32'h3000); tick();
        put(A, 1, A, 1, 32'h3000); tick();
        put(A, 0, '0, 0, '0);       expect_out(1, 3, 32'h3000, "R7"); tick();
        put(A, 1, A, 1, 32'h3000); tick();
        put(A, 0, '0, 0, '0);       expect_out(1, 3, 32'h3000, "R7"); tick();

        // R10 / R9: alias misses; not-taken alias leaves the occupant intact
        put(B, 0, '0, 0, '0);       expect_out(0, 0, B + 4, "R10");  tick();
        put(B, 1, B, 0, '0); tick();
        put(A, 0, '0, 0, '0);       expect_out(1, 3, 32'h3000, "R9"); tick();

        // R6 / R2: taken alias replaces the occupant; old address now misses
        put(B, 1, B, 1, 32'h5000); tick();
        put(B, 0, '0, 0, '0);       expect_out(1, 2, 32'h5000, "R6"); tick();
        put(A, 0, '0, 0, '0);       expect_out(0, 0, A + 4, "R2");   tick();
        put(A ^ 32'h8000_0000, 0, '0, 0, '0);
        expect_out(0, 0, (A ^ 32'h8000_0000) + 4, "R2"); tick();

        // Random traffic, reference compared on every cycle
        for (int k = 0; k < 3000; k++) begin
            logic [AW-1:0] fp  = 32'h4000 + 32'(4 * $urandom_range(0, 31));
            logic [AW-1:0] up  = 32'h4000 + 32'(4 * $urandom_range(0, 31));
            logic [AW-1:0] utg = 32'(4 * $urandom_range(0, 4095));
            put(fp, ($urandom_range(0, 3) != 0), up, $urandom_range(0, 1) == 1, utg);
            tick();
        end

        done = 1;
        summary();
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            summary();
            $finish;
        end
    end

endmodule